// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides an N-bit dividend by an N-bit divisor over N clock cycles and returns an N-bit quotient and an N-bit remainder. It uses one subtractor and one shifting accumulator. The upper part of the accumulator holds the running partial remainder. The lower part starts with the dividend and fills with quotient bits as the dividend bits move out.

The accumulator is shifted one place left when the operands are loaded. Each of the N steps then tries to subtract the divisor from the upper part. If the difference is non-negative, it is kept and a 1 enters as the quotient bit. Otherwise the old partial remainder is kept, which undoes the subtraction, and a 0 enters. Because the upper part ends one position too far left, the remainder is read from the upper part shifted right by one. The upper part is one bit wider than the operands, so a doubled partial remainder cannot overflow.

A per-operation signed flag selects two's-complement division. In that case the operands are turned into magnitudes when they are accepted, and the signs are applied to the result. A single-cycle start request begins an operation. A busy level covers the operation, and a one-cycle done pulse marks its end. A zero divisor raises a flag and still finishes in the normal time.

Top module: `rdiv_unit`

## Requirements
- R1: After synchronous reset, busy, done, div_zero, quotient and remainder are all zero.
- R2: When start is high on a rising edge while busy is low, the operands and signed_op are captured on that edge and busy is high from the next cycle. done is high, and busy is low, only in the cycle that follows the WIDTH-th rising edge after the accepting edge.
- R3: With signed_op low, quotient is floor(dividend / divisor) and remainder is dividend mod divisor, both unsigned. For example, with 4-bit operands, 7 / 2 gives quotient 3 and remainder 1.
- R4: For a nonzero divisor, the unsigned magnitude of the remainder is always smaller than the magnitude of the divisor.
- R5: With signed_op high, the quotient is truncated toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend. For example, -7 / 2 gives -3 rem -1, 7 / -2 gives -3 rem 1, and -7 / -2 gives 3 rem -1.
- R6: With signed_op high, the most negative value divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R7: A zero divisor in either mode completes with the normal latency. It sets div_zero high, quotient to all ones, and remainder equal to the original dividend.
- R8: A start while busy is high has no effect. The operands presented with it do not change the results, and completion time is unchanged.
- R9: done lasts exactly one cycle. quotient, remainder and div_zero keep their values from completion until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a division; accepted only when idle |
| signed_op | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dividend | input | WIDTH | Number to be divided |
| divisor | input | WIDTH | Number to divide by |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when results become valid |
| div_zero | output | 1 | Last completed operation had a zero divisor |
| quotient | output | WIDTH | Quotient (low half of the result pair) |
| remainder | output | WIDTH | Remainder (high half of the result pair) |

## Verification
Only one result time matters: done and the final quotient, remainder and div_zero become valid in the cycle after the WIDTH-th rising edge that follows the accepting edge, and busy is high from the cycle right after acceptance. The bench drives inputs on falling edges and counts falling edges from acceptance. It checks that done is still low after edge WIDTH-1, then checks every result output after edge WIDTH, and checks again one cycle later that done has dropped and the results have not moved. For operations where a second start is issued during busy, the same edge count is used, so a shifted completion or a corrupted result shows up at the same sampling point.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rdiv_state_e;

    // Per-operation sign bookkeeping, captured together with the operands
    typedef struct packed {
        logic quo_neg;
        logic rem_neg;
        logic div_zero;
    } rdiv_tag_t;

    function automatic rdiv_tag_t make_tag(
        input logic is_signed,
        input logic dvd_msb,
        input logic dvs_msb,
        input logic dvs_is_zero
    );
        rdiv_tag_t t;
        t.quo_neg  = is_signed & (dvd_msb ^ dvs_msb);
        t.rem_neg  = is_signed & dvd_msb;
        t.div_zero = dvs_is_zero;
        return t;
    endfunction

endpackage

// File: rtl/rdiv_sign_prep.sv
module rdiv_sign_prep
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             signed_op,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] mag_dvd,
    output logic [WIDTH-1:0] mag_dvs,
    output rdiv_tag_t        tag
);
    logic dvd_neg;
    logic dvs_neg;

    always_comb begin
        dvd_neg = signed_op & dividend[WIDTH-1];
        dvs_neg = signed_op & divisor[WIDTH-1];
        mag_dvd = dvd_neg ? (~dividend + 1'b1) : dividend;
        mag_dvs = dvs_neg ? (~divisor + 1'b1) : divisor;
        tag     = make_tag(signed_op, dividend[WIDTH-1], divisor[WIDTH-1],
                           divisor == '0);
    end
endmodule

// File: rtl/rdiv_trial_sub.sv
module rdiv_trial_sub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH:0]   part_rem,
    input  logic [WIDTH-1:0] dvs,
    output logic [WIDTH:0]   kept_rem,
    output logic             fits
);
    logic [WIDTH+1:0] diff;

    always_comb begin
        diff     = {1'b0, part_rem} - {2'b00, dvs};
        fits     = ~diff[WIDTH+1];
        kept_rem = fits ? diff[WIDTH:0] : part_rem;
    end
endmodule

// File: rtl/rdiv_core.sv
module rdiv_core
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] mag_dvd,
    input  logic [WIDTH-1:0] mag_dvs,
    input  rdiv_tag_t        tag_in,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quo_mag,
    output logic [WIDTH-1:0] rem_mag,
    output rdiv_tag_t        tag_out
);
    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    rdiv_state_e      state_q;
    logic [WIDTH:0]   hi_q;
    logic [WIDTH-1:0] lo_q;
    logic [WIDTH-1:0] dvs_q;
    logic [CW-1:0]    cnt_q;
    logic             done_q;
    rdiv_tag_t        tag_q;

    logic [WIDTH:0]   kept_rem;
    logic             fits;
    logic             accept;

    rdiv_trial_sub #(.WIDTH(WIDTH)) u_sub (
        .part_rem (hi_q),
        .dvs      (dvs_q),
        .kept_rem (kept_rem),
        .fits     (fits)
    );

    assign accept = start && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hi_q    <= '0;
            lo_q    <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            tag_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        // load with the initial one-place left shift applied
                        hi_q    <= {{WIDTH{1'b0}}, mag_dvd[WIDTH-1]};
                        lo_q    <= {mag_dvd[WIDTH-2:0], 1'b0};
                        dvs_q   <= mag_dvs;
                        tag_q   <= tag_in;
                        cnt_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    {hi_q, lo_q} <= {kept_rem[WIDTH-1:0], lo_q, fits};
                    cnt_q        <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == ST_RUN);
    assign done    = done_q;
    assign quo_mag = lo_q;
    assign rem_mag = hi_q[WIDTH:1];   // undo the extra shift on the remainder half only
    assign tag_out = tag_q;

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    a_r2_step_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt_q <= LAST_STEP));

    a_r4_partial_fits: assert property (@(posedge clk) disable iff (rst)
        busy |-> !kept_rem[WIDTH]);

    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (done_q && !tag_q.div_zero) |-> (hi_q[WIDTH:1] < dvs_q));

    a_r7_zero_div_all_ones: assert property (@(posedge clk) disable iff (rst)
        (done_q && tag_q.div_zero) |-> (lo_q == '1));

    a_r8_start_ignored_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(dvs_q) && $stable(tag_q)));

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    a_r9_results_held: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(hi_q) && $stable(lo_q) && $stable(tag_q)));
endmodule

// File: rtl/rdiv_sign_fix.sv
module rdiv_sign_fix
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] quo_mag,
    input  logic [WIDTH-1:0] rem_mag,
    input  rdiv_tag_t        tag,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    always_comb begin
        if (tag.div_zero)
            quotient = '1;
        else if (tag.quo_neg)
            quotient = ~quo_mag + 1'b1;
        else
            quotient = quo_mag;
        remainder = tag.rem_neg ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/rdiv_unit.sv
module rdiv_unit
    import rdiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             signed_op,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic [WIDTH-1:0] mag_dvd;
    logic [WIDTH-1:0] mag_dvs;
    rdiv_tag_t        tag_in;
    rdiv_tag_t        tag_out;
    logic [WIDTH-1:0] quo_mag;
    logic [WIDTH-1:0] rem_mag;

    rdiv_sign_prep #(.WIDTH(WIDTH)) u_prep (
        .signed_op (signed_op),
        .dividend  (dividend),
        .divisor   (divisor),
        .mag_dvd   (mag_dvd),
        .mag_dvs   (mag_dvs),
        .tag       (tag_in)
    );

    rdiv_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mag_dvd (mag_dvd),
        .mag_dvs (mag_dvs),
        .tag_in  (tag_in),
        .busy    (busy),
        .done    (done),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag),
        .tag_out (tag_out)
    );

    rdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
        .quo_mag   (quo_mag),
        .rem_mag   (rem_mag),
        .tag       (tag_out),
        .quotient  (quotient),
        .remainder (remainder)
    );

    assign div_zero = tag_out.div_zero;

    a_r2_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_flag_held_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(div_zero));
endmodule

// File: tb/rdiv_unit_bench.sv
module rdiv_unit_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         signed_op = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy;
    logic         done;
    logic         div_zero;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    rdiv_unit #(.WIDTH(W)) u_rdiv_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .signed_op (signed_op),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .div_zero  (div_zero),
        .quotient  (quotient),
        .remainder (remainder)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                                  output logic [W-1:0] q, output logic [W-1:0] r);
        longint sa, sb;
        if (b == '0) begin
            q = '1;
            r = a;
        end else if (!s) begin
            q = a / b;
            r = a % b;
        end else begin
            sa = longint'($signed(a));
            sb = longint'($signed(b));
            q = W'(sa / sb);
            r = W'(sa % sb);
        end
    endfunction

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input logic intrude, input string req);
        logic [W-1:0] eq, er;
        model(a, b, s, eq, er);
        @(negedge clk);
        dividend  = a;
        divisor   = b;
        signed_op = s;
        start     = 1'b1;
        @(negedge clk);                        // accepting edge has passed
        start = 1'b0;
        check("R2 busy after accept", W'(busy), W'(1));
        dividend  = ~a;
        divisor   = b ^ 32'h5A5A_0001;
        signed_op = ~s;
        if (intrude) start = 1'b1;             // R8: request while busy
        for (int e = 1; e < W; e++) begin
            @(negedge clk);
            if (e == 1) start = 1'b0;
        end
        check("R2 done not early", W'(done), W'(0));
        @(negedge clk);                        // after the W-th edge
        check("R2 done at latency", W'(done), W'(1));
        check("R2 busy low at done", W'(busy), W'(0));
        check({req, " quotient"}, quotient, eq);
        check({req, " remainder"}, remainder, er);
        check("R7 div_zero flag", W'(div_zero), W'(b == '0));
        @(negedge clk);
        check("R9 done single cycle", W'(done), W'(0));
        check("R9 quotient held", quotient, eq);
        check("R9 remainder held", remainder, er);
        check("R9 div_zero held", W'(div_zero), W'(b == '0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb;
        logic rs;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset busy", W'(busy), W'(0));
        check("R1 reset done", W'(done), W'(0));
        check("R1 reset div_zero", W'(div_zero), W'(0));
        check("R1 reset quotient", quotient, '0);
        check("R1 reset remainder", remainder, '0);

        run_op(32'd7, 32'd2, 1'b0, 1'b0, "R3 7/2");
        run_op(-32'sd7, 32'd2, 1'b1, 1'b0, "R5 -7/2");
        run_op(32'd7, -32'sd2, 1'b1, 1'b1, "R5 7/-2");
        run_op(-32'sd7, -32'sd2, 1'b1, 1'b0, "R5 -7/-2");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, "R6 min/-1");
        run_op(32'h1234_5678, 32'd0, 1'b0, 1'b0, "R7 zero divisor unsigned");
        run_op(32'hF000_0003, 32'd0, 1'b1, 1'b1, "R7 zero divisor signed");
        run_op(32'd0, 32'd5, 1'b0, 1'b0, "R3 zero dividend");
        run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, "R3 max/1");
        run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, "R3 max/max");
        run_op(32'd5, 32'hFFFF_FFF0, 1'b0, 1'b0, "R4 small/large");
        run_op(32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 1'b0, "R4 max/msb");
        run_op(32'h8000_0000, 32'd3, 1'b1, 1'b1, "R8 min/3 intrude");

        for (int n = 0; n < 200; n++) begin
            ra = W'($urandom);
            rb = W'($urandom) >> ($urandom % 32);
            rs = 1'($urandom);
            run_op(ra, rb, rs, (n % 5) == 0, rs ? "R5 random signed" : "R3 random unsigned");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule